// File: doc/BRIEF.md
# Receiver Lock Status and Mute Controller

This block sits beside the decoder of a serial digital-audio receiver and decides when the received stream can be trusted. It watches rising-edge events from the input line and declares a stream present once enough edges have arrived. It declares the stream lost when the line goes quiet for longer than a programmable number of system clocks. It combines that with the lock indication of the external clock generator to drive three outputs: an unlock flag, a clock-transition flag and a mute request for the serial data output.

Two kinds of failure are treated differently. A parity error in one subframe raises the unlock flag for that subframe only, and the output is not muted. A loss of signal mutes the output at once. It raises the unlock flag at the next transition of the output word clock, and keeps both asserted for a minimum hold time counted in ticks of an external millisecond timebase, even if the stream returns sooner.

The block also turns a detected sample-rate class into a 2-bit rate indicator. It loads this indicator only when lock is reached, so the value stays stable while the receiver is unlocked.

Top module: `rx_lock_mon`

## Requirements
- R1: A stream is declared present on the 10th rising-edge event (`EDGE_COUNT`). If `QUIET_CYCLES` system clocks pass with no edge before that, the count restarts from zero. Before the declaration, `clk_trans` is 0 while `pll_locked` is 0.
- R2: After the stream is declared present, `mute` and `unlock` stay 1 until `pll_locked` is sampled 1. Both are 0 in the cycle after the edge that samples it.
- R3: When the stream is declared lost, `mute` goes to 1 immediately. `unlock` stays 0 until the first clock edge at which `word_clk` differs from its previously sampled value, and is 1 after that edge.
- R4: After a loss, `unlock` and `mute` stay 1 for `HOLD_MS` pulses of `ms_tick`, counted from the word-clock transition, whatever the input stream and `pll_locked` do.
- R5: While locked, a `sf_strobe` with `sf_parity_err`=1 sets `unlock` to 1 from the next cycle. `unlock` remains 1 until a `sf_strobe` with `sf_parity_err`=0, after which it is 0 again. `mute` stays 0 throughout.
- R6: `clk_trans` is 1 for `STARTUP_CYCLES` clocks after reset is released. Afterwards it is 1 exactly while the stream is present and `pll_locked` is 0.
- R7: On reaching lock, `rate_ind` is loaded from `rate_class`, where class 0 = 32 kHz gives 2'b11, class 1 = 44.1 kHz gives 2'b00, class 2 = 48 kHz gives 2'b01, and class 3 = 88.2 kHz and class 4 = 96 kHz both give 2'b10.
- R8: While `rst_n` is sampled 0 (synchronous reset), `unlock`=1, `clk_trans`=1, `mute`=1 and `rate_ind`=2'b00.
- R9: `rate_ind` keeps its value at all times other than the transition into lock; changes on `rate_class` while locked or unlocked have no effect on it.
- R10: A present stream is declared lost only after `QUIET_CYCLES` consecutive system clocks without an edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_edge | input | 1 | One-cycle pulse per rising edge seen on the input line |
| sf_strobe | input | 1 | One-cycle pulse at the end of each received subframe |
| sf_parity_err | input | 1 | Parity result of the subframe, valid with `sf_strobe` |
| pll_locked | input | 1 | Lock indication from the output clock generator |
| word_clk | input | 1 | Output word (left/right) clock level |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| rate_class | input | 3 | Detected sample-rate class, 0 to 4 |
| unlock | output | 1 | Stream not trusted (loss, acquisition or parity error) |
| clk_trans | output | 1 | Output clock not yet valid or retuning |
| mute | output | 1 | Request to hold the serial data output low |
| rate_ind | output | 2 | Encoded sample-rate class of the locked stream |

## Verification
The assertions take for granted that `line_edge`, `sf_strobe` and `ms_tick` are single-cycle pulses synchronous to `clk`. They also assume `word_clk` has been synchronised to `clk` and that `rate_class` only carries the values 0 to 4. The bench produces edge events from a pulse generator with a fixed four-cycle spacing, which is far inside the quiet timeout. It produces millisecond ticks every fifth cycle, and changes `word_clk` only at chosen points. Random parity patterns and random rate classes are mixed with directed cases for the nine-edge burst, the two rates that share one code, and the hold window around a quick return of the stream.

// File: rtl/rx_lock_pkg.sv
// Shared types for the receiver lock monitor.
// Assumes rate classes 0..4 only; other values encode as 2'b00.
package rx_lock_pkg;

    typedef enum logic [2:0] {
        ST_START    = 3'd0,  // post-reset start-up, clock not valid
        ST_WAIT     = 3'd1,  // no stream
        ST_ACQ      = 3'd2,  // stream present, waiting for clock lock
        ST_LOCK     = 3'd3,  // trusted stream
        ST_LOSS_ARM = 3'd4,  // stream lost, waiting for word-clock transition
        ST_HOLD     = 3'd5   // minimum unlock window
    } lock_state_t;

    typedef enum logic [2:0] {
        RC_32K  = 3'd0,
        RC_44K1 = 3'd1,
        RC_48K  = 3'd2,
        RC_88K2 = 3'd3,
        RC_96K  = 3'd4
    } rate_class_t;

    // Maps a rate class to the 2-bit indicator code.
    function automatic logic [1:0] rate_code(input logic [2:0] rc);
        case (rc)
            RC_32K:  return 2'b11;
            RC_44K1: return 2'b00;
            RC_48K:  return 2'b01;
            RC_88K2: return 2'b10;
            RC_96K:  return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/rx_activity_det.sv
// Stream activity detector.
// Declares a stream present on the EDGE_COUNT-th edge event and lost after
// QUIET_CYCLES clocks with no edge. A quiet gap before detection restarts the
// edge count. Held cleared while enable is low.
// Assumes line_edge is a one-cycle pulse synchronous to clk.
module rx_activity_det #(
    parameter int EDGE_COUNT   = 10,
    parameter int QUIET_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_edge,
    output logic present
);
    localparam int EW = $clog2(EDGE_COUNT);
    localparam int QW = $clog2(QUIET_CYCLES);
    localparam logic [EW-1:0] EDGE_LAST  = EW'(EDGE_COUNT - 1);
    localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_CYCLES - 1);

    logic [EW-1:0] edge_cnt;
    logic [QW-1:0] quiet_cnt;

    // Counts edges towards detection and quiet cycles towards loss.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            present   <= 1'b0;
            edge_cnt  <= '0;
            quiet_cnt <= '0;
        end else begin
            if (line_edge) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt != QUIET_LAST) begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end

            if (present) begin
                if (!line_edge && quiet_cnt == QUIET_LAST) begin
                    present  <= 1'b0;
                    edge_cnt <= '0;
                end
            end else if (line_edge) begin
                if (edge_cnt == EDGE_LAST) begin
                    present <= 1'b1;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end else if (quiet_cnt == QUIET_LAST) begin
                edge_cnt <= '0;
            end
        end
    end

    AST_DETECT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present) |-> $past(line_edge)); // R1

    AST_LOSS_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(present) && $past(enable)) |-> !$past(line_edge)); // R10

endmodule

// File: rtl/rx_rate_ind.sv
// Sample-rate indicator register.
// Loads the encoded rate class only when load is high; holds otherwise.
// Assumes rate_class is stable in the cycle of load.
module rx_rate_ind (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] rate_class,
    output logic [1:0] rate_ind
);
    import rx_lock_pkg::*;

    // Captures the rate code at the moment of lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_ind <= 2'b00;
        end else if (load) begin
            rate_ind <= rate_code(rate_class);
        end
    end

    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rate_ind)); // R9

endmodule

// File: rtl/rx_lock_fsm.sv
// Lock state machine.
// Sequences start-up, acquisition, lock, loss and the minimum unlock window,
// and tracks a per-subframe parity flag while locked.
// Assumes word_clk is synchronous to clk and ms_tick is a one-cycle pulse.
module rx_lock_fsm #(
    parameter int STARTUP_CYCLES = 32,
    parameter int HOLD_MS        = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic present,
    input  logic pll_locked,
    input  logic sf_strobe,
    input  logic sf_parity_err,
    input  logic word_clk,
    input  logic ms_tick,
    output logic detect_en,
    output logic rate_load,
    output logic unlock,
    output logic clk_trans,
    output logic mute
);
    import rx_lock_pkg::*;

    localparam int SW = $clog2(STARTUP_CYCLES);
    localparam int HW = $clog2(HOLD_MS);
    localparam logic [SW-1:0] START_LAST = SW'(STARTUP_CYCLES - 1);
    localparam logic [HW-1:0] HOLD_LAST  = HW'(HOLD_MS - 1);

    lock_state_t   state, state_nx;
    logic [SW-1:0] start_cnt;
    logic [HW-1:0] hold_cnt;
    logic          wclk_q;
    logic          par_flag;
    logic          wc_edge;

    assign wc_edge = (word_clk != wclk_q);

    // Next-state decision.
    always_comb begin
        state_nx = state;
        case (state)
            ST_START:    if (start_cnt == START_LAST) state_nx = ST_WAIT;
            ST_WAIT:     if (present) state_nx = ST_ACQ;
            ST_ACQ:      if (!present) state_nx = ST_WAIT;
                         else if (pll_locked) state_nx = ST_LOCK;
            ST_LOCK:     if (!present) state_nx = ST_LOSS_ARM;
            ST_LOSS_ARM: if (wc_edge) state_nx = ST_HOLD;
            ST_HOLD:     if (ms_tick && hold_cnt == HOLD_LAST)
                             state_nx = present ? ST_ACQ : ST_WAIT;
            default:     state_nx = ST_START;
        endcase
    end

    // State register with start-up and hold counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_START;
            start_cnt <= '0;
            hold_cnt  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_START) start_cnt <= start_cnt + 1'b1;
            if (state != ST_HOLD) hold_cnt <= '0;
            else if (ms_tick) hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // Word-clock history for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wclk_q <= 1'b0;
        else        wclk_q <= word_clk;
    end

    // Parity flag: set by an errored subframe, cleared by a clean one.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_LOCK) par_flag <= 1'b0;
        else if (sf_strobe)             par_flag <= sf_parity_err;
    end

    // Output decode.
    always_comb begin
        detect_en = (state != ST_START);
        rate_load = (state == ST_ACQ) && present && pll_locked;
        mute      = (state != ST_LOCK);
        clk_trans = (state == ST_START) || (present && !pll_locked);
        case (state)
            ST_LOCK:     unlock = par_flag;
            ST_LOSS_ARM: unlock = 1'b0;
            default:     unlock = 1'b1;
        endcase
    end

    AST_RESET_OUTPUTS: assert property (@(posedge clk)
        !rst_n |=> (unlock && clk_trans && mute)); // R8

    AST_UNMUTE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> ($past(pll_locked) && $past(present))); // R2

    AST_UNLOCK_WAITS_WCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOSS_ARM && word_clk == wclk_q) |=> (!unlock && mute)); // R3

    AST_HOLD_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_cnt != HOLD_LAST) |=> (unlock && mute)); // R4

    AST_PARITY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && sf_strobe && !sf_parity_err) |=> !unlock); // R5

    AST_PARITY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && present && sf_strobe && sf_parity_err) |=> (unlock && !mute)); // R5

endmodule

// File: rtl/rx_lock_mon.sv
// Receiver lock status and mute controller (top).
// Combines stream activity detection, the lock state machine and the rate
// indicator register. Assumes all inputs are synchronous to clk.
module rx_lock_mon #(
    parameter int EDGE_COUNT     = 10,
    parameter int QUIET_CYCLES   = 64,
    parameter int STARTUP_CYCLES = 32,
    parameter int HOLD_MS        = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_edge,
    input  logic       sf_strobe,
    input  logic       sf_parity_err,
    input  logic       pll_locked,
    input  logic       word_clk,
    input  logic       ms_tick,
    input  logic [2:0] rate_class,
    output logic       unlock,
    output logic       clk_trans,
    output logic       mute,
    output logic [1:0] rate_ind
);
    logic present;
    logic detect_en;
    logic rate_load;

    rx_activity_det #(
        .EDGE_COUNT  (EDGE_COUNT),
        .QUIET_CYCLES(QUIET_CYCLES)
    ) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (detect_en),
        .line_edge(line_edge),
        .present  (present)
    );

    rx_lock_fsm #(
        .STARTUP_CYCLES(STARTUP_CYCLES),
        .HOLD_MS       (HOLD_MS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .present      (present),
        .pll_locked   (pll_locked),
        .sf_strobe    (sf_strobe),
        .sf_parity_err(sf_parity_err),
        .word_clk     (word_clk),
        .ms_tick      (ms_tick),
        .detect_en    (detect_en),
        .rate_load    (rate_load),
        .unlock       (unlock),
        .clk_trans    (clk_trans),
        .mute         (mute)
    );

    rx_rate_ind u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rate_load),
        .rate_class(rate_class),
        .rate_ind  (rate_ind)
    );

    AST_RESET_RATE: assert property (@(posedge clk)
        !rst_n |=> (rate_ind == 2'b00)); // R8

    AST_RATE_ONLY_AT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_ind) |-> $fell(mute)); // R7

endmodule

// File: tb/rx_lock_mon_tb.sv
module rx_lock_mon_tb;
    localparam int EDGE_COUNT     = 10;
    localparam int QUIET_CYCLES   = 64;
    localparam int STARTUP_CYCLES = 32;
    localparam int HOLD_MS        = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_edge = 1'b0;
    logic       sf_strobe = 1'b0;
    logic       sf_parity_err = 1'b0;
    logic       pll_locked = 1'b0;
    logic       word_clk = 1'b0;
    logic       ms_tick = 1'b0;
    logic [2:0] rate_class = 3'd1;
    logic       unlock, clk_trans, mute;
    logic [1:0] rate_ind;

    int checks = 0;
    int errors = 0;
    bit stream_on = 1'b0;
    int edge_budget = 0;
    logic [1:0] held_rate;

    always #4 clk = ~clk;

    rx_lock_mon #(
        .EDGE_COUNT(EDGE_COUNT), .QUIET_CYCLES(QUIET_CYCLES),
        .STARTUP_CYCLES(STARTUP_CYCLES), .HOLD_MS(HOLD_MS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .line_edge(line_edge), .sf_strobe(sf_strobe),
        .sf_parity_err(sf_parity_err), .pll_locked(pll_locked), .word_clk(word_clk),
        .ms_tick(ms_tick), .rate_class(rate_class), .unlock(unlock),
        .clk_trans(clk_trans), .mute(mute), .rate_ind(rate_ind)
    );

    function automatic logic [1:0] exp_rate(input int rc);
        case (rc)
            0: return 2'b11;
            1: return 2'b00;
            2: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Edge event generator: one pulse every fourth cycle.
    initial begin
        int gap = 0;
        forever begin
            @(posedge clk);
            #1;
            if (gap == 0 && (stream_on || edge_budget > 0)) begin
                line_edge = 1'b1;
                if (!stream_on) edge_budget--;
                gap = 3;
            end else begin
                line_edge = 1'b0;
                if (gap > 0) gap--;
            end
        end
    end

    // Millisecond timebase: one pulse every fifth cycle.
    initial begin
        int div = 0;
        forever begin
            @(posedge clk);
            #1;
            ms_tick = (div == 4);
            div = (div == 4) ? 0 : div + 1;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'hC0DE));
        repeat (3) tick();
        // R8: reset state
        check("R8 unlock in reset", unlock, 1);
        check("R8 clk_trans in reset", clk_trans, 1);
        check("R8 mute in reset", mute, 1);
        check("R8 rate in reset", rate_ind, 0);

        rst_n = 1'b1;
        repeat (10) tick();
        check("R6 clk_trans during start-up", clk_trans, 1);
        repeat (30) tick();
        check("R6 clk_trans after start-up", clk_trans, 0);
        check("R2 unlock with no stream", unlock, 1);

        // R1: nine edges then a quiet gap restart the count
        edge_budget = 9;
        wait (edge_budget == 0);
        repeat (80) tick();
        check("R1 nine edges not detected", clk_trans, 0);
        edge_budget = 9;
        wait (edge_budget == 0);
        repeat (3) tick();
        check("R1 count restarted after quiet gap", clk_trans, 0);
        edge_budget = 1;
        wait (edge_budget == 0);
        repeat (3) tick();
        check("R1 detected on tenth edge", clk_trans, 1);
        stream_on = 1'b1;
        rate_class = 3'd2;
        repeat (20) tick();
        check("R2 muted before lock", mute, 1);
        check("R2 unlocked before lock", unlock, 1);
        check("R9 rate unchanged before lock", rate_ind, 0);
        pll_locked = 1'b1;
        tick();
        check("R2 mute released at lock", mute, 0);
        check("R2 unlock released at lock", unlock, 0);
        check("R7 rate 48k", rate_ind, exp_rate(2));
        check("R6 clk_trans low when locked", clk_trans, 0);

        // R5: random parity pattern
        for (int i = 0; i < 40; i++) begin
            bit err;
            err = 1'($urandom_range(0, 1));
            sf_strobe = 1'b1;
            sf_parity_err = err;
            tick();
            sf_strobe = 1'b0;
            sf_parity_err = 1'b0;
            check("R5 unlock follows subframe parity", unlock, err);
            check("R5 no mute on parity", mute, 0);
            repeat ($urandom_range(0, 3)) tick();
            check("R5 unlock held within subframe", unlock, err);
        end
        sf_strobe = 1'b1;
        tick();
        sf_strobe = 1'b0;
        check("R5 clean subframe clears unlock", unlock, 0);

        // R9: rate class change while locked is ignored
        rate_class = 3'd0;
        repeat (10) tick();
        check("R9 rate ignored while locked", rate_ind, exp_rate(2));

        // Loss and hold, directed then random rates
        held_rate = exp_rate(2);
        for (int it = 0; it < 6; it++) begin
            int rc;
            rc = (it < 2) ? 3 + it : (it == 2 ? 0 : int'($urandom_range(0, 4)));
            stream_on = 1'b0;
            repeat (40) tick();
            check("R10 not lost before quiet timeout", mute, 0);
            repeat (40) tick();
            check("R3 muted after loss", mute, 1);
            check("R3 unlock waits for word clock", unlock, 0);
            word_clk = ~word_clk;
            tick();
            check("R3 unlock at word clock transition", unlock, 1);
            rate_class = 3'(rc);
            pll_locked = 1'b0;
            stream_on = 1'b1;
            repeat (60) tick();
            check("R6 clk_trans while retuning", clk_trans, 1);
            pll_locked = 1'b1;
            repeat (300) tick();
            check("R4 unlock held after quick return", unlock, 1);
            check("R4 mute held after quick return", mute, 1);
            check("R9 rate held while unlocked", rate_ind, held_rate);
            repeat (800) tick();
            check("R4 unlock cleared after hold", unlock, 0);
            check("R7 rate code after relock", rate_ind, exp_rate(rc));
            held_rate = exp_rate(rc);
        end

        // R8: reset during operation
        rst_n = 1'b0;
        tick();
        check("R8 unlock on reset", unlock, 1);
        check("R8 clk_trans on reset", clk_trans, 1);
        check("R8 rate on reset", rate_ind, 0);
        check("R8 mute on reset", mute, 1);
        rst_n = 1'b1;
        stream_on = 1'b0;
        repeat (5) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule